// File: doc/BRIEF.md
# IOMMU Page Translation Lookup

This block translates device DMA bus addresses into physical addresses through a table of translation entries. Each 64-bit entry holds a page-aligned target frame in its upper bits. A 2-bit access code sits in its two lowest bits. A request carries a bus address and a direction flag. The block splits the address into a page number and an in-page offset, using a parameterised page shift. It reads the entry for that page and returns a response. The response holds the page-aligned request address, the translated frame, the physical address (frame plus offset), the in-page offset mask, the access code, and a fault flag raised when the direction is not allowed.

Addresses beyond the table window do not produce an error response. They produce a no-access result. On reset a walker zeroes the table one entry per cycle, and the request side is held off until the walk completes, so every page faults until software programs it. A separate write port programs entries. Both the request and the response sides use a valid/ready handshake, and the response is registered one cycle after acceptance.

Top module: `iommu_xlate`

## Requirements
- R1: After reset release the block holds `req_ready` low for exactly DEPTH clock cycles while it zeroes every table entry. It keeps `rsp_valid` low through reset. A lookup of any in-window page that has not been written since reset then returns access code 0 with `rsp_fault` high.
- R2: Bits [1:0] of an entry are the access code, returned on `rsp_perm`: 0 gives no access, 1 gives read only, 2 gives write only and 3 gives read and write.
- R3: The page index is `req_addr >> PAGE_SHIFT`. When that index is DEPTH or more, the response has `rsp_perm` 0, `rsp_iova`, `rsp_xaddr` and `rsp_phys` all zero, `rsp_mask` all ones and `rsp_fault` high.
- R4: For an in-window lookup with page mask M = ~(2^PAGE_SHIFT - 1), `rsp_iova` is `req_addr & M`, `rsp_xaddr` is `entry & M` (so the code bits and other low entry bits are dropped) and `rsp_mask` is ~M.
- R5: For an in-window lookup, `rsp_phys` is `rsp_xaddr` ORed with `req_addr & ~M`.
- R6: `rsp_fault` is high when a write request (`req_write`=1) meets a code with bit 1 clear, or a read request meets a code with bit 0 clear. Otherwise it is low.
- R7: A request accepted on a clock edge (`req_valid` and `req_ready` high) appears on the response outputs after that edge with `rsp_valid` high. While `rsp_valid` is high and `rsp_ready` low, the response holds stable and `req_ready` is low. When `rsp_ready` is high, a new request is accepted in the same cycle the old response leaves.
- R8: A write (`wr_en` with `wr_index` below DEPTH) stores `wr_entry` for lookups accepted on later edges. A lookup accepted on the same edge sees the previous contents. A write issued while the reset walker runs is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Bus address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_iova | output | ADDR_W | Page-aligned request address |
| rsp_xaddr | output | ADDR_W | Translated page frame |
| rsp_phys | output | ADDR_W | Frame plus in-page offset |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Access code of the entry |
| rsp_fault | output | 1 | Direction not permitted |
| wr_en | input | 1 | Table write strobe |
| wr_index | input | IDX_W | Entry to write |
| wr_entry | input | ENTRY_W | Entry value |

## Verification
The bench aims at the clear walker's length and at a write slipped in mid-walk. A design that cleared too quickly or too slowly would raise ready on the wrong cycle, and one that let the write land would return a live permission for a page that should fault. It probes the window edge: the last valid page, the first page past it, and an address with high bits set. A truncated index compare would alias those addresses onto real entries instead of returning the all-ones mask. Entries with junk in the bits under the page mask, all four access codes in both directions, a stalled response with a competing request, and a write racing a lookup to the same page expose leaked low bits, a swapped read/write bit, responses that change while stalled, and a lookup that sees the new value too early.

// File: rtl/iommu_xlate_pkg.sv
package iommu_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2,
      ACC_RW   = 2'd3
   } acc_e;

   // read right lives in bit 0, write right in bit 1
   function automatic logic acc_denied(input acc_e code, input logic is_wr);
      logic [1:0] raw;
      raw = code;
      return is_wr ? ~raw[1] : ~raw[0];
   endfunction

   function automatic int unsigned idx_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/xlate_table_store.sv
module xlate_table_store #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned ENTRY_W   = 64,
   parameter int unsigned IDX_W     = 4,
   parameter bit          SEQ_CLEAR = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_entry,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic               busy
);

   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DEPTH - 1);
   localparam logic [IDX_W:0]   DEPTH_EXT = (IDX_W + 1)'(DEPTH);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic               wr_ok;
   logic               rd_ok;

   assign wr_ok = wr_en && ({1'b0, wr_idx} < DEPTH_EXT);
   assign rd_ok = {1'b0, rd_idx} < DEPTH_EXT;
   assign rd_entry = rd_ok ? mem[rd_idx] : '0;

   initial begin
      assert (DEPTH >= 1) else $error("table depth must be at least one");
      assert ((1 << IDX_W) >= DEPTH) else $error("index width too small");
   end

   generate
      if (SEQ_CLEAR) begin : g_walk_clear
         logic [IDX_W-1:0] clr_idx;
         logic             clr_busy;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               clr_idx  <= '0;
               clr_busy <= 1'b1;
            end else if (clr_busy) begin
               clr_idx <= (clr_idx == LAST_IDX) ? '0 : clr_idx + 1'b1;
               if (clr_idx == LAST_IDX) begin
                  clr_busy <= 1'b0;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (rst_n) begin
               if (clr_busy) begin
                  mem[clr_idx] <= '0;
               end else if (wr_ok) begin
                  mem[wr_idx] <= wr_entry;
               end
            end
         end

         assign busy = clr_busy;

         // the walk ends only after visiting the last entry
         p_clear_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clr_busy) |-> $past(clr_idx) == LAST_IDX)
            else $error("clear walk ended early");

      end else begin : g_flop_clear
         logic flop_busy;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flop_busy <= 1'b1;
            end else begin
               flop_busy <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(DEPTH); i++) begin
                  mem[i] <= '0;
               end
            end else if (wr_ok && !flop_busy) begin
               mem[wr_idx] <= wr_entry;
            end
         end

         assign busy = flop_busy;
      end
   endgenerate

endmodule

// File: rtl/xlate_index_check.sv
module xlate_index_check #(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned IDX_W      = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              in_range
);

   localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

   logic [ADDR_W-1:0] page_num;

   initial begin
      assert (PAGE_SHIFT < ADDR_W) else $error("page shift exceeds address width");
      assert (IDX_W <= ADDR_W) else $error("index wider than address");
   end

   assign page_num = addr >> PAGE_SHIFT;
   assign in_range = page_num < DEPTH_A;
   assign idx      = page_num[IDX_W-1:0];

endmodule

// File: rtl/xlate_perm_check.sv
module xlate_perm_check
   import iommu_xlate_pkg::*;
(
   input  logic [1:0] entry_code,
   input  logic       in_range,
   input  logic       is_wr,
   output acc_e       eff_code,
   output logic       fault
);

   assign eff_code = in_range ? acc_e'(entry_code) : ACC_NONE;
   assign fault    = acc_denied(eff_code, is_wr);

endmodule

// File: rtl/iommu_xlate.sv
module iommu_xlate
   import iommu_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned ENTRY_W    = 64,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned DEPTH      = 16,
   parameter bit          SEQ_CLEAR  = 1'b1,
   localparam int unsigned IDX_W     = idx_width(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_write,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [ADDR_W-1:0]  rsp_iova,
   output logic [ADDR_W-1:0]  rsp_xaddr,
   output logic [ADDR_W-1:0]  rsp_phys,
   output logic [ADDR_W-1:0]  rsp_mask,
   output logic [1:0]         rsp_perm,
   output logic               rsp_fault,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_index,
   input  logic [ENTRY_W-1:0] wr_entry
);

   localparam logic [ADDR_W-1:0] OFS_MASK  = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] PAGE_MASK = ~OFS_MASK;

   initial begin
      assert (PAGE_SHIFT >= 2) else $error("access code must fit below the page frame");
      assert (ADDR_W <= ENTRY_W) else $error("entry narrower than address");
   end

   logic [IDX_W-1:0]   look_idx;
   logic               look_in;
   logic [ENTRY_W-1:0] look_entry;
   acc_e               look_code;
   logic               look_fault;
   logic               store_busy;
   logic               accept;

   logic [ADDR_W-1:0]  nx_iova;
   logic [ADDR_W-1:0]  nx_xaddr;
   logic [ADDR_W-1:0]  nx_phys;
   logic [ADDR_W-1:0]  nx_mask;

   xlate_index_check #(
      .ADDR_W     (ADDR_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .DEPTH      (DEPTH),
      .IDX_W      (IDX_W)
   ) u_index (
      .addr     (req_addr),
      .idx      (look_idx),
      .in_range (look_in)
   );

   xlate_table_store #(
      .DEPTH     (DEPTH),
      .ENTRY_W   (ENTRY_W),
      .IDX_W     (IDX_W),
      .SEQ_CLEAR (SEQ_CLEAR)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_index),
      .wr_entry (wr_entry),
      .rd_idx   (look_idx),
      .rd_entry (look_entry),
      .busy     (store_busy)
   );

   xlate_perm_check u_perm (
      .entry_code (look_entry[1:0]),
      .in_range   (look_in),
      .is_wr      (req_write),
      .eff_code   (look_code),
      .fault      (look_fault)
   );

   always_comb begin
      if (look_in) begin
         nx_iova  = req_addr & PAGE_MASK;
         nx_xaddr = look_entry[ADDR_W-1:0] & PAGE_MASK;
         nx_mask  = OFS_MASK;
         nx_phys  = nx_xaddr | (req_addr & OFS_MASK);
      end else begin
         nx_iova  = '0;
         nx_xaddr = '0;
         nx_mask  = '1;
         nx_phys  = '0;
      end
   end

   assign req_ready = !store_busy && (!rsp_valid || rsp_ready);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
      end else if (accept) begin
         rsp_valid <= 1'b1;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_iova  <= '0;
         rsp_xaddr <= '0;
         rsp_phys  <= '0;
         rsp_mask  <= '1;
         rsp_perm  <= ACC_NONE;
         rsp_fault <= 1'b0;
      end else if (accept) begin
         rsp_iova  <= nx_iova;
         rsp_xaddr <= nx_xaddr;
         rsp_phys  <= nx_phys;
         rsp_mask  <= nx_mask;
         rsp_perm  <= look_code;
         rsp_fault <= look_fault;
      end
   end

   p_no_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      store_busy |-> !req_ready)
      else $error("request accepted during table clear");

   p_oob_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_mask == '1) |-> (rsp_perm == 2'd0) && (rsp_xaddr == '0) && rsp_fault)
      else $error("out-of-window result carries access");

   p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_iova & rsp_mask) == '0) && ((rsp_xaddr & rsp_mask) == '0))
      else $error("page addresses not aligned to mask");

   p_phys_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_mask != '1) |-> (rsp_phys & ~rsp_mask) == rsp_xaddr)
      else $error("physical address frame mismatch");

   p_code_none_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_perm == 2'd0) |-> rsp_fault)
      else $error("no-access code without fault");

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_phys) && $stable(rsp_perm)
                                  && $stable(rsp_fault) && $stable(rsp_mask))
      else $error("response changed while stalled");

   p_accept_to_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid)
      else $error("accepted request produced no response");

endmodule

// File: tb/tb_iommu_xlate.sv
module tb_iommu_xlate;

   localparam int unsigned ADDR_W = 64;
   localparam int unsigned ENTRY_W = 64;
   localparam int unsigned PSHIFT = 12;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned IDX_W = 4;
   localparam logic [63:0] OFS = 64'h0000_0000_0000_0FFF;
   localparam logic [63:0] PM = ~OFS;

   typedef struct packed {
      logic [63:0] addr;
      logic        wr;
      logic [1:0]  perm;
      logic        fault;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{64'h0000_0000_0000_0ABC, 1'b0, 2'd3, 1'b0},
      '{64'h0000_0000_0000_0ABC, 1'b1, 2'd3, 1'b0},
      '{64'h0000_0000_0000_1010, 1'b0, 2'd1, 1'b0},
      '{64'h0000_0000_0000_1010, 1'b1, 2'd1, 1'b1},
      '{64'h0000_0000_0000_2FF8, 1'b0, 2'd2, 1'b1},
      '{64'h0000_0000_0000_2FF8, 1'b1, 2'd2, 1'b0},
      '{64'h0000_0000_0000_3000, 1'b0, 2'd0, 1'b1},
      '{64'h0000_0000_0000_FFFF, 1'b1, 2'd3, 1'b0},
      '{64'h0000_0000_0001_0000, 1'b0, 2'd0, 1'b1},
      '{64'hFFFF_0000_0000_0001, 1'b1, 2'd0, 1'b1},
      '{64'h0000_0000_0000_4004, 1'b0, 2'd0, 1'b1},
      '{64'h0000_0001_0000_0000, 1'b0, 2'd0, 1'b1}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic               req_ready;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic               req_write = 1'b0;
   logic               rsp_valid;
   logic               rsp_ready = 1'b1;
   logic [ADDR_W-1:0]  rsp_iova, rsp_xaddr, rsp_phys, rsp_mask;
   logic [1:0]         rsp_perm;
   logic               rsp_fault;
   logic               wr_en = 1'b0;
   logic [IDX_W-1:0]   wr_index = '0;
   logic [ENTRY_W-1:0] wr_entry = '0;

   int checks = 0;
   int errors = 0;
   logic [63:0] shadow [DEPTH];

   always #4 clk = ~clk;

   iommu_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_iova(rsp_iova), .rsp_xaddr(rsp_xaddr), .rsp_phys(rsp_phys),
      .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
      .wr_en(wr_en), .wr_index(wr_index), .wr_entry(wr_entry)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tbl_write(input int idx, input logic [63:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_index = IDX_W'(idx); wr_entry = val;
      @(negedge clk);
      wr_en = 1'b0;
      shadow[idx] = val;
   endtask

   task automatic lookup(input logic [63:0] a, input logic w);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // expected addresses from the requirements (R3, R4, R5)
   task automatic check_addrs(input logic [63:0] a, input string tag);
      logic [63:0] pg, e, x_iova, x_xa, x_mask, x_phys;
      pg = a >> PSHIFT;
      if (pg >= 64'(DEPTH)) begin
         x_iova = '0; x_xa = '0; x_mask = '1; x_phys = '0;
      end else begin
         e = shadow[pg[3:0]];
         x_iova = a & PM; x_xa = e & PM; x_mask = OFS; x_phys = x_xa | (a & OFS);
      end
      chk(rsp_iova == x_iova, tag, "iova", rsp_iova, x_iova);
      chk(rsp_xaddr == x_xa, tag, "xaddr", rsp_xaddr, x_xa);
      chk(rsp_mask == x_mask, tag, "mask", rsp_mask, x_mask);
      chk(rsp_phys == x_phys, tag, "phys", rsp_phys, x_phys);
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 64 && !req_ready; k++) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [63:0] held;
      for (int i = 0; i < int'(DEPTH); i++) shadow[i] = '0;

      // R1: reset state and clear length; R8: write during clear dropped
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0, "R1", "ready in reset", 64'(req_ready), 64'd0);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      wr_en = 1'b1; wr_index = 4'd0; wr_entry = 64'h0000_0000_ABCD_0003;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (DEPTH - 3) @(negedge clk);
      chk(req_ready == 1'b0, "R1", "ready before clear done", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after DEPTH cycles", 64'(req_ready), 64'd1);
      lookup(64'h0000_0000_0000_0040, 1'b0);
      chk(rsp_valid == 1'b1, "R7", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rsp_perm == 2'd0, "R8", "write in clear dropped perm", 64'(rsp_perm), 64'd0);
      chk(rsp_fault == 1'b1, "R1", "cleared page faults", 64'(rsp_fault), 64'd1);

      // R1: a second reset wipes programmed entries
      tbl_write(6, 64'h0000_0000_0BAD_0003);
      lookup(64'h0000_0000_0000_6000, 1'b1);
      chk(rsp_perm == 2'd3, "R8", "written entry visible", 64'(rsp_perm), 64'd3);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      shadow[6] = '0;
      wait_ready();
      lookup(64'h0000_0000_0000_6000, 1'b1);
      chk(rsp_perm == 2'd0, "R1", "entry cleared by reset", 64'(rsp_perm), 64'd0);
      chk(rsp_fault == 1'b1, "R1", "fault after reset", 64'(rsp_fault), 64'd1);

      // program entries; index 1 carries junk under the page mask
      tbl_write(0, 64'h0000_00AB_CDE0_1003);
      tbl_write(1, 64'h0000_0000_7777_7FF1);
      tbl_write(2, 64'h0000_0012_3456_7002);
      tbl_write(3, 64'h0000_0000_0009_9000);
      tbl_write(15, 64'hFFFF_FFFF_FFFF_F003);

      // vector table: R2 codes, R3 window, R4/R5 addresses, R6 fault
      for (int v = 0; v < NV; v++) begin
         lookup(VECS[v].addr, VECS[v].wr);
         chk(rsp_perm == VECS[v].perm, "R2", $sformatf("perm v%0d", v),
             64'(rsp_perm), 64'(VECS[v].perm));
         chk(rsp_fault == VECS[v].fault, "R6", $sformatf("fault v%0d", v),
             64'(rsp_fault), 64'(VECS[v].fault));
         check_addrs(VECS[v].addr, (VECS[v].addr >> PSHIFT) >= 64'(DEPTH) ? "R3" : "R4_R5");
      end

      // R7: back-pressure holds the response and blocks a new request
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_addr = 64'h0000_0000_0000_1234; req_write = 1'b0;
      @(negedge clk);
      req_addr = 64'h0000_0000_0000_2008; req_write = 1'b1;
      chk(rsp_valid == 1'b1, "R7", "rsp_valid stalled", 64'(rsp_valid), 64'd1);
      chk(req_ready == 1'b0, "R7", "ready low when stalled", 64'(req_ready), 64'd0);
      held = rsp_phys;
      repeat (3) @(negedge clk);
      chk(rsp_phys == held, "R7", "phys held", rsp_phys, held);
      chk(rsp_perm == 2'd1, "R7", "perm held", 64'(rsp_perm), 64'd1);
      chk(rsp_phys == 64'h0000_0000_7777_7234, "R5", "stalled phys",
          rsp_phys, 64'h0000_0000_7777_7234);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R7", "next rsp same cycle", 64'(rsp_valid), 64'd1);
      chk(rsp_perm == 2'd2, "R7", "second request perm", 64'(rsp_perm), 64'd2);
      chk(rsp_fault == 1'b0, "R6", "write on write-only", 64'(rsp_fault), 64'd0);
      chk(rsp_phys == 64'h0000_0012_3456_7008, "R5", "second phys",
          rsp_phys, 64'h0000_0012_3456_7008);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R7", "rsp drained", 64'(rsp_valid), 64'd0);

      // R8: write and lookup on the same edge see old contents
      @(negedge clk);
      wr_en = 1'b1; wr_index = 4'd7; wr_entry = 64'h0000_0055_5000_0003;
      req_valid = 1'b1; req_addr = 64'h0000_0000_0000_7010; req_write = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      chk(rsp_perm == 2'd0, "R8", "same-edge lookup old perm", 64'(rsp_perm), 64'd0);
      chk(rsp_fault == 1'b1, "R8", "same-edge lookup faults", 64'(rsp_fault), 64'd1);
      shadow[7] = 64'h0000_0055_5000_0003;
      lookup(64'h0000_0000_0000_7010, 1'b0);
      chk(rsp_perm == 2'd3, "R8", "later lookup new perm", 64'(rsp_perm), 64'd3);
      chk(rsp_phys == 64'h0000_0055_5000_0010, "R8", "later phys",
          rsp_phys, 64'h0000_0055_5000_0010);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule